// File: doc/BRIEF.md
# Serial DAC Command Port

This block is the digital front end of a 13-bit voltage DAC. A host talks to it over a three-wire serial link: an active-low select, a serial clock and a data input. A data output lets several converters be chained. Each transaction carries a 3-bit opcode followed by a 13-bit code. When select rises, the opcode is acted on. It can load a staging (input) register, load the staging and converter (DAC) registers together, or copy staging into the converter register. It can also request power-down, drive a general-purpose output pin, or choose the clock edge on which the chain output moves.

All pins are sampled by the system clock through a synchronizer, so the block lives in one clock domain. Power-down and wake requests leave as single-cycle pulses for a separate power controller. While the block is powered down it keeps its chain output and general-purpose pin frozen. The clear input returns both code registers to the reset code and the general-purpose pin to low, and it wakes the block.

Top module: `dac_serial_port`

## Requirements
- R1: A transaction is the last 16 bits shifted in before select rises, most significant bit first; bits [15:13] are the opcode and [12:0] the code. Extra leading clocks are discarded, a word may be split into pauses with select held low, and a transaction with no clocks re-executes the word already held.
- R2: Serial clock edges seen while select is high shift nothing.
- R3: Opcode 001 writes the code into the staging register (`in_code`) and leaves `dac_code` unchanged.
- R4: Opcode 010 writes the code into both registers. If the block is powered down, it also wakes it and issues one `wake_pulse`.
- R5: Opcode 011 copies `in_code` into `dac_code`. If the block is powered down, it also wakes it and issues one `wake_pulse`.
- R6: Opcode 000, and opcode 111 with code bits [12:11] equal to 01, change no state.
- R7: Opcode 101 powers the block down and issues one `shdn_pulse`, but only when `lockout_n` is high. With `lockout_n` low it has no effect.
- R8: Opcode 110 drives `user_out` high and opcode 100 drives it low.
- R9: Opcode 111 with code bit 12 set makes `dout` move on serial clock rising edges, which gives a 15.5-clock lag from `din`. With code bits [12:11] = 00, `dout` moves on falling edges, which gives a 16-clock lag. Falling-edge mode is the reset mode.
- R10: While powered down, `dout` and `user_out` hold their values, and opcodes 100 and 110 are ignored.
- R11: A high `clr` sets both code registers to the reset code and `user_out` low. If the block is powered down, `clr` wakes it with one `wake_pulse`.
- R12: After reset both code registers hold the reset code (0 by default), `user_out` and `dout` are low, and falling-edge mode is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low select; its rising edge executes the word |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data in, sampled on sclk rising edges |
| lockout_n | input | 1 | Low forbids power-down |
| clr | input | 1 | Synchronous clear of both code registers and `user_out` |
| dout | output | 1 | Chain output, delayed copy of `din` |
| user_out | output | 1 | General-purpose output pin |
| in_code | output | 13 | Staging register |
| dac_code | output | 13 | Converter register |
| shdn_pulse | output | 1 | One-cycle power-down request |
| wake_pulse | output | 1 | One-cycle wake request |

## Verification
Every pin passes two synchronizer stages and one edge-history flop. The code registers, `user_out` and the pulses therefore change on the third clock edge after the select rising edge that reaches the pins. `dout` moves on the third clock edge after the matching serial clock edge. The bench holds each serial clock half period for five system clocks and reads `dout` at the end of each half period. It waits eight clocks after select rises before reading the registers. The pulses last one clock, so they are tallied by a monitor on every clock edge and the tallies are compared after each transaction.

// File: rtl/dac_sp_pkg.sv
// Package: shared opcode encoding for the serial DAC command port.
// Assumes a fixed 3-bit opcode field at the top of every word.
package dac_sp_pkg;

    localparam int CMD_W = 3;

    typedef enum logic [CMD_W-1:0] {
        OP_NOP       = 3'b000,
        OP_LOAD_IN   = 3'b001,
        OP_LOAD_BOTH = 3'b010,
        OP_UPDATE    = 3'b011,
        OP_USER_LO   = 3'b100,
        OP_SLEEP     = 3'b101,
        OP_USER_HI   = 3'b110,
        OP_OUT_EDGE  = 3'b111
    } op_e;

endpackage

// File: rtl/dsp_sync.sv
// Module: multi-stage synchronizer for a bundle of asynchronous pins.
// Assumes each bit is independent; RST_VAL gives the idle level of every bit.
module dsp_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] st [STAGES];

    // Purpose: first stage captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) st[0] <= RST_VAL;
        else        st[0] <= d;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            // Purpose: each later stage settles metastability further.
            always_ff @(posedge clk) begin
                if (!rst_n) st[g] <= RST_VAL;
                else        st[g] <= st[g-1];
            end
        end
    endgenerate

    assign q = st[STAGES-1];

endmodule

// File: rtl/dsp_shifter.sv
// Module: serial shift register, edge detection and chain output.
// Assumes synchronized inputs; shifts on sclk rise while select is low and
// drives dout on the edge chosen by rise_mode, frozen while hold is high.
module dsp_shifter #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               s_cs_n,
    input  logic               s_sclk,
    input  logic               s_din,
    input  logic               rise_mode,
    input  logic               hold,
    output logic [FRAME_W-1:0] frame,
    output logic               frame_done,
    output logic               dout
);

    logic               sclk_q;
    logic               cs_q;
    logic [FRAME_W-1:0] sr_q;
    logic               dout_q;
    logic               sel;
    logic               sclk_rise;
    logic               sclk_fall;

    assign sel        = ~s_cs_n;
    assign sclk_rise  = s_sclk & ~sclk_q;
    assign sclk_fall  = ~s_sclk & sclk_q;
    assign frame_done = s_cs_n & ~cs_q;

    // Purpose: remember last synchronized clock and select for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= s_sclk;
            cs_q   <= s_cs_n;
        end
    end

    // Purpose: shift serial data in, MSB first, on selected rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n)                sr_q <= '0;
        else if (sel && sclk_rise) sr_q <= {sr_q[FRAME_W-2:0], s_din};
    end

    // Purpose: drive chain output on the chosen clock edge unless held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= 1'b0;
        end else if (!hold && sel) begin
            if (rise_mode && sclk_rise)       dout_q <= sr_q[FRAME_W-2];
            else if (!rise_mode && sclk_fall) dout_q <= sr_q[FRAME_W-1];
        end
    end

    assign frame = sr_q;
    assign dout  = dout_q;

    // R2: nothing shifts while select is high.
    p_shift_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_cs_n |=> $stable(sr_q));

    // R10: chain output frozen while powered down.
    p_dout_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(dout_q));

endmodule

// File: rtl/dsp_cmd_exec.sv
// Module: opcode decoder with staging/converter registers, user pin,
// chain-edge mode and power state. Assumes frame_done is a one-cycle strobe
// and that lockout_n and clr are already synchronous to clk.
module dsp_cmd_exec
    import dac_sp_pkg::*;
#(
    parameter int   DATA_W    = 13,
    parameter logic RESET_MID = 1'b0,
    localparam int  FRAME_W   = DATA_W + CMD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] frame,
    input  logic               frame_done,
    input  logic               lockout_n,
    input  logic               clr,
    output logic [DATA_W-1:0]  in_code,
    output logic [DATA_W-1:0]  dac_code,
    output logic               user_out,
    output logic               rise_mode,
    output logic               asleep,
    output logic               shdn_pulse,
    output logic               wake_pulse
);

    localparam logic [DATA_W-1:0] RST_CODE =
        RESET_MID ? {1'b1, {(DATA_W-1){1'b0}}} : '0;

    op_e               op;
    logic [DATA_W-1:0] data;
    logic [DATA_W-1:0] in_q, dac_q;
    logic              user_q, rise_q, asleep_q, shdn_q, wake_q;

    assign op   = op_e'(frame[FRAME_W-1 -: CMD_W]);
    assign data = frame[DATA_W-1:0];

    // Purpose: execute the held word on select rise; clear has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q     <= RST_CODE;
            dac_q    <= RST_CODE;
            user_q   <= 1'b0;
            rise_q   <= 1'b0;
            asleep_q <= 1'b0;
            shdn_q   <= 1'b0;
            wake_q   <= 1'b0;
        end else begin
            shdn_q <= 1'b0;
            wake_q <= 1'b0;
            if (clr) begin
                in_q     <= RST_CODE;
                dac_q    <= RST_CODE;
                user_q   <= 1'b0;
                asleep_q <= 1'b0;
                wake_q   <= asleep_q;
            end else if (frame_done) begin
                case (op)
                    OP_LOAD_IN: in_q <= data;
                    OP_LOAD_BOTH: begin
                        in_q     <= data;
                        dac_q    <= data;
                        asleep_q <= 1'b0;
                        wake_q   <= asleep_q;
                    end
                    OP_UPDATE: begin
                        dac_q    <= in_q;
                        asleep_q <= 1'b0;
                        wake_q   <= asleep_q;
                    end
                    OP_SLEEP: begin
                        if (lockout_n && !asleep_q) begin
                            asleep_q <= 1'b1;
                            shdn_q   <= 1'b1;
                        end
                    end
                    OP_USER_LO: if (!asleep_q) user_q <= 1'b0;
                    OP_USER_HI: if (!asleep_q) user_q <= 1'b1;
                    OP_OUT_EDGE: begin
                        if (data[DATA_W-1])      rise_q <= 1'b1;
                        else if (!data[DATA_W-2]) rise_q <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign in_code    = in_q;
    assign dac_code   = dac_q;
    assign user_out   = user_q;
    assign rise_mode  = rise_q;
    assign asleep     = asleep_q;
    assign shdn_pulse = shdn_q;
    assign wake_pulse = wake_q;

    // R3: converter register moves only on a transaction or clear.
    p_dac_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_done && !clr) |=> $stable(dac_q));

    // R7: power-down request only while lockout_n was high.
    p_sleep_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_q |-> $past(lockout_n));

    // R4: a wake pulse only leaves the powered-down state.
    p_wake_from_sleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |-> $past(asleep_q));

    // R11: the two requests never coincide.
    p_pulse_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(shdn_q && wake_q));

    // R10: user pin frozen while powered down unless cleared.
    p_user_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep_q && !clr) |=> $stable(user_q));

endmodule

// File: rtl/dac_serial_port.sv
// Module: top of the serial DAC command port. Synchronizes the serial pins,
// shifts words in and executes them on select rise. Assumes clk is several
// times faster than sclk so every serial edge is seen by the edge detectors.
module dac_serial_port #(
    parameter int   DATA_W      = 13,
    parameter int   SYNC_STAGES = 2,
    parameter logic RESET_MID   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    input  logic              lockout_n,
    input  logic              clr,
    output logic              dout,
    output logic              user_out,
    output logic [DATA_W-1:0] in_code,
    output logic [DATA_W-1:0] dac_code,
    output logic              shdn_pulse,
    output logic              wake_pulse
);

    localparam int FRAME_W = DATA_W + dac_sp_pkg::CMD_W;

    logic [2:0]         pins_s;
    logic [FRAME_W-1:0] frame;
    logic               frame_done;
    logic               rise_mode;
    logic               asleep;

    dsp_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sclk, din}),
        .q     (pins_s)
    );

    dsp_shifter #(
        .FRAME_W (FRAME_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .s_cs_n     (pins_s[2]),
        .s_sclk     (pins_s[1]),
        .s_din      (pins_s[0]),
        .rise_mode  (rise_mode),
        .hold       (asleep),
        .frame      (frame),
        .frame_done (frame_done),
        .dout       (dout)
    );

    dsp_cmd_exec #(
        .DATA_W    (DATA_W),
        .RESET_MID (RESET_MID)
    ) u_exec (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame      (frame),
        .frame_done (frame_done),
        .lockout_n  (lockout_n),
        .clr        (clr),
        .in_code    (in_code),
        .dac_code   (dac_code),
        .user_out   (user_out),
        .rise_mode  (rise_mode),
        .asleep     (asleep),
        .shdn_pulse (shdn_pulse),
        .wake_pulse (wake_pulse)
    );

endmodule

// File: tb/dac_serial_port_tb_top.sv
// Bench: vector table of single transactions, then directed tests for
// reset, select gating, framing, chain-output lag, power-down and clear.
module dac_serial_port_tb_top;

    localparam int HALF = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        din = 1'b0;
    logic        lockout_n = 1'b1;
    logic        clr = 1'b0;
    logic        dout, user_out, shdn_pulse, wake_pulse;
    logic [12:0] in_code, dac_code;

    int checks = 0;
    int errors = 0;
    int shdn_cnt = 0;
    int wake_cnt = 0;
    int nbit = 0;
    logic lo_s [0:63];
    logic hi_s [0:63];

    always #5 clk = ~clk;

    dac_serial_port dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .din        (din),
        .lockout_n  (lockout_n),
        .clr        (clr),
        .dout       (dout),
        .user_out   (user_out),
        .in_code    (in_code),
        .dac_code   (dac_code),
        .shdn_pulse (shdn_pulse),
        .wake_pulse (wake_pulse)
    );

    // Pulse tallies, one per clock edge.
    always @(posedge clk) begin
        if (rst_n && shdn_pulse) shdn_cnt <= shdn_cnt + 1;
        if (rst_n && wake_pulse) wake_cnt <= wake_cnt + 1;
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [31:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            din  = bits[i];
            sclk = 1'b0;
            wait_clk(HALF);
            nbit++;
            lo_s[nbit] = dout;
            sclk = 1'b1;
            wait_clk(HALF);
            hi_s[nbit] = dout;
        end
        sclk = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic send_word(input logic [15:0] w);
        cs_n = 1'b0;
        nbit = 0;
        wait_clk(HALF);
        send_bits({16'h0, w}, 16);
        cs_n = 1'b1;
        wait_clk(8);
    endtask

    // Chain lag: word A then a NOP, sample dout at end of each high phase.
    task automatic lag_pass(input logic exp_rise, input string req);
        logic [15:0] a;
        int bad;
        a = 16'h1A5C;
        bad = 0;
        cs_n = 1'b0;
        nbit = 0;
        wait_clk(HALF);
        send_bits({a, 16'h0000}, 32);
        cs_n = 1'b1;
        wait_clk(8);
        for (int j = 17; j <= 31; j++) begin
            if (exp_rise) begin
                if (hi_s[j] !== a[31-j]) bad++;
            end else begin
                if (hi_s[j] !== a[32-j]) bad++;
            end
        end
        check(req, bad, 0);
    endtask

    localparam logic [42:0] VEC [10] = '{
        {16'h2ABC, 13'h0ABC, 13'h0000, 1'b0},
        {16'h6000, 13'h0ABC, 13'h0ABC, 1'b0},
        {16'h5FFF, 13'h1FFF, 13'h1FFF, 1'b0},
        {16'h2001, 13'h0001, 13'h1FFF, 1'b0},
        {16'h1234, 13'h0001, 13'h1FFF, 1'b0},
        {16'hC000, 13'h0001, 13'h1FFF, 1'b1},
        {16'hE800, 13'h0001, 13'h1FFF, 1'b1},
        {16'h8000, 13'h0001, 13'h1FFF, 1'b0},
        {16'h6000, 13'h0001, 13'h0001, 1'b0},
        {16'h4000, 13'h0000, 13'h0000, 1'b0}
    };

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic held_dout;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);

        // R12 reset state
        check("R12 in_code", in_code, 0);
        check("R12 dac_code", dac_code, 0);
        check("R12 user_out", user_out, 0);
        check("R12 dout", dout, 0);

        // Vector table: R3 R4 R5 R6 R8
        for (int v = 0; v < 10; v++) begin
            send_word(VEC[v][42:27]);
            check("R3/R4/R5/R6 in_code", in_code, VEC[v][26:14]);
            check("R3/R4/R5/R6 dac_code", dac_code, VEC[v][13:1]);
            check("R8 user_out", user_out, VEC[v][0]);
        end
        check("R4 no wake while awake", wake_cnt, 0);

        // R2: clocks with select high are ignored; R1 empty frame re-executes
        send_word(16'h2155);
        cs_n = 1'b1;
        send_bits({16'h0, 16'h5FFF}, 16);
        cs_n = 1'b0;
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(8);
        check("R2 dac_code unchanged", dac_code, 0);
        check("R1 empty frame in_code", in_code, 13'h0155);

        // R1 long frame: leading bits discarded
        cs_n = 1'b0;
        wait_clk(HALF);
        send_bits({8'h0, 8'hFF, 16'h4123}, 24);
        cs_n = 1'b1;
        wait_clk(8);
        check("R1 long frame dac_code", dac_code, 13'h0123);

        // R1 split transfer with a pause, select low throughout
        cs_n = 1'b0;
        wait_clk(HALF);
        send_bits({24'h0, 8'h2A}, 8);
        wait_clk(20);
        send_bits({24'h0, 8'hAA}, 8);
        cs_n = 1'b1;
        wait_clk(8);
        check("R1 split in_code", in_code, 13'h0AAA);
        check("R1 split dac_code", dac_code, 13'h0123);

        // R9 / R6: chain-output edge and lag
        lag_pass(1'b0, "R9 falling lag 16");
        send_word(16'hF000);
        lag_pass(1'b1, "R9 rising lag 15.5");
        send_word(16'hE800);
        lag_pass(1'b1, "R6 edge select 01 is no-op");
        send_word(16'hE000);
        lag_pass(1'b0, "R9 back to falling");

        // R7: lockout blocks power-down
        send_word(16'hC000);
        lockout_n = 1'b0;
        send_word(16'hA000);
        check("R7 lockout blocks", shdn_cnt, 0);
        lockout_n = 1'b1;
        send_word(16'hA000);
        check("R7 power-down pulse", shdn_cnt, 1);

        // R10: outputs held while powered down
        held_dout = dout;
        send_word(16'h8000);
        check("R10 user_out held", user_out, 1);
        begin
            int bad;
            bad = 0;
            for (int j = 1; j <= 16; j++) begin
                if (lo_s[j] !== held_dout || hi_s[j] !== held_dout) bad++;
            end
            check("R10 dout held", bad, 0);
        end

        // R5: update wakes
        send_word(16'h6000);
        check("R5 wake pulse", wake_cnt, 1);
        check("R5 dac_code", dac_code, 13'h0AAA);

        // R11: clear while powered down
        send_word(16'hA000);
        check("R7 second power-down", shdn_cnt, 2);
        clr = 1'b1;
        wait_clk(1);
        clr = 1'b0;
        wait_clk(3);
        check("R11 wake pulse", wake_cnt, 2);
        check("R11 user_out", user_out, 0);
        check("R11 dac_code", dac_code, 0);
        check("R11 in_code", in_code, 0);

        // R4: load both wakes from power-down
        send_word(16'hA000);
        send_word(16'h4777);
        check("R4 wake pulse", wake_cnt, 3);
        check("R4 dac_code", dac_code, 13'h0777);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule